// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block forms the word address that a synchronous burst memory array sees. On any rising clock edge where either of two active-low address strobes is low, it captures the full external address. The two lowest bits of that address become the start offset of a four-beat burst. On later edges where the active-low advance input is low and no strobe is low, the low two bits step to the next beat. The upper bits stay where they were loaded.

An active-low order-select input picks the beat sequence. When it is low the sequence is linear: the start offset plus the beat count, modulo four. When it is high the sequence is interleaved: the start offset XOR the beat count. After the fourth beat the sequence comes back to the start offset. Bursts are optional: a caller may strobe a new address on every cycle, and each one appears on the output one edge later, with no idle cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and after it is released, the address output reads all zeros until the first load.
- R2: On a rising edge where either strobe (`strb_a_n` or `strb_b_n`) is low, the output takes the full external address after that edge.
- R3: A load happens on each edge that sees a strobe low, back to back, with no idle cycle between loads.
- R4: A load takes priority over an advance requested on the same edge.
- R5: On an edge with both strobes high and `adv_n` high, the output holds its value.
- R6: With `lin_n` low, the low two bits on advance k (k = 0..3) equal (start + k) mod 4. For example, start 1 gives 1,2,3,0.
- R7: With `lin_n` high, the low two bits on advance k equal start XOR k. For example, start 1 gives 1,0,3,2.
- R8: The fourth advance of a burst returns the low two bits to the start offset, and the sequence then repeats.
- R9: The bits above the low two never change on an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_addr | input | ADDR_W | External address sampled on a load |
| strb_a_n | input | 1 | First address strobe, active low |
| strb_b_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance request, active low |
| lin_n | input | 1 | Order select: low gives linear order, high gives interleaved order |
| mem_addr | output | ADDR_W | Word address presented to the memory array |

## Verification
The hardest case to reach from the ports is the wrap after four advances in each ordering mode. It only shows up when the burst begins at a nonzero offset, because a start of zero makes the two orders look alike on the first beats. The bench starts bursts at every offset in both modes and advances five times. This covers the wrap back to the start and the first beat after it. Separate tasks cover a strobe and an advance on the same edge, and a strobe on every edge with a new address each time.

// File: rtl/burst_addr_pkg.sv
// Shared types for the burst address generator.
// Assumes the burst always spans exactly four words (two offset bits).
package burst_addr_pkg;
    localparam int unsigned OFS_W = 2;

    // Next-state choice for the address register
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } act_e;

    // Linear order: start plus beat count, modulo four
    function automatic logic [OFS_W-1:0] ofs_linear(input logic [OFS_W-1:0] base,
                                                   input logic [OFS_W-1:0] beat);
        return base + beat;
    endfunction

    // Interleaved order: start XOR beat count
    function automatic logic [OFS_W-1:0] ofs_xor(input logic [OFS_W-1:0] base,
                                                input logic [OFS_W-1:0] beat);
        return base ^ beat;
    endfunction
endpackage

// File: rtl/burst_ctl.sv
// Decodes the strobes and the advance request into one action per edge.
// Assumes every control input is active low and sampled on the rising edge.
// A load always wins over a step.
module burst_ctl
    import burst_addr_pkg::*;
(
    input  logic strb_a_n,
    input  logic strb_b_n,
    input  logic adv_n,
    output act_e act
);
    // Priority decode: load, then step, then hold
    always_comb begin
        if (!strb_a_n || !strb_b_n) act = ACT_LOAD;
        else if (!adv_n)            act = ACT_STEP;
        else                        act = ACT_HOLD;
    end
endmodule

// File: rtl/burst_seq.sv
// Holds the start offset and the beat count and forms the current low bits.
// Assumes the beat count wraps modulo four, so a burst returns to its start.
module burst_seq
    import burst_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  act_e             act,
    input  logic [OFS_W-1:0] ld_ofs,
    input  logic             lin_n,
    output logic [OFS_W-1:0] cur_ofs
);
    logic [OFS_W-1:0] base_q;
    logic [OFS_W-1:0] beat_q;

    // Capture the start offset on a load and advance the beat count on a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    base_q <= ld_ofs;
                    beat_q <= '0;
                end
                ACT_STEP: beat_q <= beat_q + 1'b1;
                default:  ;
            endcase
        end
    end

    // Apply the selected ordering to the start offset and beat count
    always_comb begin
        cur_ofs = lin_n ? ofs_xor(base_q, beat_q) : ofs_linear(base_q, beat_q);
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Top level: captures the external address on a strobe and steps its two
// low bits through a four-beat burst on each advance.
// Assumes ADDR_W > 2 and that lin_n stays steady for the length of a burst.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strb_a_n,
    input  logic              strb_b_n,
    input  logic              adv_n,
    input  logic              lin_n,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int unsigned HI_W = ADDR_W - OFS_W;

    act_e             act;
    logic [HI_W-1:0]  hi_q;
    logic [OFS_W-1:0] ofs;

    burst_ctl u_ctl (
        .strb_a_n (strb_a_n),
        .strb_b_n (strb_b_n),
        .adv_n    (adv_n),
        .act      (act)
    );

    burst_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .ld_ofs  (ext_addr[OFS_W-1:0]),
        .lin_n   (lin_n),
        .cur_ofs (ofs)
    );

    // Keep the upper address bits; they change only on a load
    always_ff @(posedge clk) begin
        if (!rst_n)               hi_q <= '0;
        else if (act == ACT_LOAD) hi_q <= ext_addr[ADDR_W-1:OFS_W];
    end

    // Put the upper bits and the sequenced offset together
    always_comb mem_addr = {hi_q, ofs};
endmodule

// File: rtl/burst_addr_chk.sv
// Checker for burst_addr_gen, attached with bind. It only observes ports.
module burst_addr_chk #(
    parameter int unsigned ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strb_a_n,
    input logic              strb_b_n,
    input logic              adv_n,
    input logic              lin_n,
    input logic [ADDR_W-1:0] mem_addr
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> mem_addr == '0); // R1
    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_a_n || !strb_b_n) |=> mem_addr == $past(ext_addr)); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_a_n && !adv_n) |=> mem_addr == $past(ext_addr)); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_a_n && strb_b_n && adv_n && $stable(lin_n)) |=> $stable(mem_addr)); // R5
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_a_n && strb_b_n) |=> mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2])); // R9
    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_a_n && strb_b_n && !adv_n && !lin_n && $past(!lin_n) && $past(rst_n))
        |=> mem_addr[1:0] != $past(mem_addr[1:0])); // R6
endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .strb_a_n (strb_a_n),
    .strb_b_n (strb_b_n),
    .adv_n    (adv_n),
    .lin_n    (lin_n),
    .mem_addr (mem_addr)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
    localparam int    AW     = 18;
    localparam time   CLK_PD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strb_a_n = 1'b1, strb_b_n = 1'b1, adv_n = 1'b1, lin_n = 1'b1;
    logic [AW-1:0] mem_addr;
    int            n_cmp = 0, n_bad = 0;

    burst_addr_gen #(.ADDR_W(AW)) u0 (.*);

    always #(CLK_PD/2) clk = ~clk;

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_cmp++;
        if (mem_addr !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, mem_addr, exp);
        end
    endtask

    // Drive inputs after the falling edge, let the rising edge pass, then sample.
    task automatic cyc(input logic sa, input logic sb, input logic av, input logic [AW-1:0] a);
        @(negedge clk);
        strb_a_n = sa; strb_b_n = sb; adv_n = av; ext_addr = a;
        @(negedge clk);
        strb_a_n = 1'b1; strb_b_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0);
    endtask

    task automatic t_bursts(input logic lin);
        lin_n = lin;
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] a = {16'h5A3C ^ 16'(s), 2'(s)};
            cyc(s[0], !s[0], 1'b1, a);
            check("R2", a);
            for (int k = 1; k <= 5; k++) begin
                logic [1:0] e = lin ? (2'(s) ^ 2'(k)) : (2'(s) + 2'(k));
                cyc(1'b1, 1'b1, 1'b0, '1);
                check(lin ? "R7" : "R6", {a[AW-1:2], e});
                check("R9", {a[AW-1:2], mem_addr[1:0]});
                if (k == 4) check("R8", a);
            end
        end
    endtask

    task automatic t_priority_hold();
        logic [AW-1:0] a = 18'h2BEEF;
        lin_n = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 18'h11112);
        cyc(1'b1, 1'b1, 1'b0, '0);
        cyc(1'b1, 1'b0, 1'b0, a);
        check("R4", a);
        repeat (3) @(negedge clk);
        check("R5", a);
        @(negedge clk);
        ext_addr = 18'h3FFFF;
        repeat (2) @(negedge clk);
        check("R5", a);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            logic [AW-1:0] a = 18'(i * 18'h0A5B7 + 3);
            strb_a_n = i[0]; strb_b_n = !i[0]; adv_n = 1'b0; ext_addr = a;
            @(negedge clk);
            check("R3", a);
        end
        strb_a_n = 1'b1; strb_b_n = 1'b1; adv_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_bursts(1'b0);
        t_bursts(1'b1);
        t_priority_hold();
        t_back_to_back();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PD * 5000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule